// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

The block is one general-purpose I/O port of eight pins, driven from a simple register bus. It has two registers. A direction register sets each pin to output or input. A data register holds the level that each output pin drives. The direction register cannot be read back. The data register can be read, and a read of it returns a per-bit mix: bits set to output return the latched data value, and bits set to input return the level seen on the pin.

The port acts as general I/O only when the mode input selects single-chip operation (mode 7). Any other mode value hands the pins to external bus logic, and this block then releases every output enable. Hardware standby works like a reset: it clears both registers and releases the pins. Software standby freezes the registers, so any pin set as an output keeps driving its level.

Top module: `gpio_port8`

## Requirements
- R1: While rst_n is low, and after it is released with no write, pin_out and pin_oe are 8'h00 and bus_rdata is 8'h00.
- R2: A write with bus_we high selects the direction register when bus_sel is 0 and the data register when bus_sel is 1. The new value appears at the ports from the first rising clock edge that samples the strobe.
- R3: In mode 7, pin_oe equals the direction register bit for bit. A 1 means the pin drives and a 0 means the pin is an input.
- R4: In any mode other than 7 (0 to 6), pin_oe is 8'h00 whatever the direction register holds. The direction register keeps its value, and it takes effect again when mode returns to 7.
- R5: A read with bus_sel at 0 returns 8'hFF, whatever the direction register holds.
- R6: A read with bus_sel at 1 returns, for each bit, the data register bit where the direction bit is 1 and the synchronised pin level where it is 0.
- R7: Read data is registered. It updates on the edge that samples bus_re and holds at other times. The pin levels pass through two flops before the read multiplexer, so a pin change first shows in read data that is captured on the third edge after the change.
- R8: pin_out always equals the data register, bit for bit, whatever the direction or mode.
- R9: While hw_stby is high, pin_oe is 8'h00 at once. Both registers are cleared at the next edge, and writes are ignored.
- R10: While sw_stby is high and hw_stby is low, writes are ignored and both registers keep their values. Pins set as outputs keep driving their data bits.
- R11: When hw_stby and sw_stby are both high, hardware standby wins and the registers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby: clears the registers and releases the pins |
| sw_stby | input | 1 | Software standby: freezes the registers |
| mode | input | 3 | Operating mode; 7 selects single-chip I/O |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 direction, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Levels driven onto the pads |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
A corrupted direction bit shows on pin_oe at once in mode 7. It also changes the choice between latch and pin in the next data read. A corrupted data bit shows on pin_out in the same cycle. A missing or extra synchroniser stage moves the cycle in which a pin change first reaches read data, so the bench reads on every cycle after a pin edge to find the exact cycle of arrival. Standby faults show as a driven pin that changes while frozen, or as register values that outlive hardware standby.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int          WIDTH       = 8,
  parameter logic [2:0]  SINGLE_CHIP = 3'd7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic [2:0]       mode,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic             bus_sel,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  logic [WIDTH-1:0] dir_q, dat_q, meta_q, sync_q, rd_q;

  wire wr_ok  = bus_we & ~hw_stby & ~sw_stby;
  wire single = (mode == SINGLE_CHIP);
  wire [WIDTH-1:0] port_view = (dir_q & dat_q) | (~dir_q & sync_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (hw_stby) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (wr_ok) begin
      if (bus_sel) dat_q <= bus_wdata;
      else         dir_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (bus_re) rd_q <= bus_sel ? port_view : '1;
  end

  assign bus_rdata = rd_q;
  assign pin_out   = dat_q;
  assign pin_oe    = (single && !hw_stby) ? dir_q : '0;

endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_stby,
  input logic             sw_stby,
  input logic [2:0]       mode,
  input logic             bus_we,
  input logic             bus_re,
  input logic             bus_sel,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe
);

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && bus_sel && !hw_stby && !sw_stby) |-> pin_out == $past(bus_wdata));

  // R4
  bus_mode_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd7) |-> pin_oe == '0);

  // R5
  dir_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re && !bus_sel) |-> bus_rdata == '1);

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bus_re) |-> $stable(bus_rdata));

  // R9
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hw_stby) |-> (pin_out == '0 && pin_oe == '0));

  // R10
  sw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && $past(sw_stby) && !hw_stby && !$past(hw_stby) && $stable(mode))
      |-> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_port8 gpio_port8_chk #(.WIDTH(WIDTH)) i_gpio_port8_chk (
  .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby), .mode(mode),
  .bus_we(bus_we), .bus_re(bus_re), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_port8.sv
`timescale 1ns/1ps
module test_gpio_port8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_stby = 1'b0, sw_stby = 1'b0;
  logic [2:0] mode = 3'd7;
  logic       bus_we = 1'b0, bus_re = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0, pin_in = '0;
  logic [7:0] bus_rdata, pin_out, pin_oe;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  gpio_port8 i_gpio_port8 (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby), .mode(mode),
    .bus_we(bus_we), .bus_re(bus_re), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk); bus_re = 1'b1; bus_sel = sel;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe in reset", pin_oe, 8'h00);
    chk("R1 out in reset", pin_out, 8'h00);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b1, v);
    chk("R1 data after reset", v, 8'h00);
  endtask

  task automatic t_write_and_oe;
    logic [7:0] v;
    wr(1'b0, 8'h0F);
    chk("R2 R3 oe follows dir", pin_oe, 8'h0F);
    wr(1'b1, 8'hC3);
    chk("R2 R8 pin_out follows data", pin_out, 8'hC3);
    rd(1'b0, v);
    chk("R5 dir read ones", v, 8'hFF);
    wr(1'b0, 8'h00);
    rd(1'b0, v);
    chk("R5 dir read ones with zero dir", v, 8'hFF);
    chk("R8 pin_out with inputs", pin_out, 8'hC3);
  endtask

  task automatic t_read_mix;
    logic [7:0] v;
    wr(1'b0, 8'hF0);
    wr(1'b1, 8'h5A);
    @(negedge clk); pin_in = 8'h39;
    repeat (3) @(negedge clk);
    rd(1'b1, v);
    chk("R6 mix F0", v, 8'h59);
    wr(1'b0, 8'h3C);
    rd(1'b1, v);
    chk("R6 mix 3C", v, 8'h19);
  endtask

  task automatic t_sync;
    @(negedge clk); wr(1'b0, 8'h00);
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hA5; bus_re = 1'b1; bus_sel = 1'b1;
    @(negedge clk); chk("R7 edge1", bus_rdata, 8'h00);
    @(negedge clk); chk("R7 edge2", bus_rdata, 8'h00);
    @(negedge clk); chk("R7 edge3", bus_rdata, 8'hA5);
    bus_re = 1'b0; pin_in = 8'h11;
    repeat (4) @(negedge clk);
    chk("R7 hold without read", bus_rdata, 8'hA5);
  endtask

  task automatic t_modes;
    wr(1'b0, 8'hAA);
    @(negedge clk); mode = 3'd3;
    @(negedge clk); chk("R4 mode3 released", pin_oe, 8'h00);
    mode = 3'd0;
    @(negedge clk); chk("R4 mode0 released", pin_oe, 8'h00);
    mode = 3'd6;
    @(negedge clk); chk("R4 mode6 released", pin_oe, 8'h00);
    mode = 3'd7;
    @(negedge clk); chk("R4 R3 dir kept", pin_oe, 8'hAA);
  endtask

  task automatic t_sw_stby;
    logic [7:0] v;
    wr(1'b0, 8'hF0);
    wr(1'b1, 8'hAA);
    @(negedge clk); sw_stby = 1'b1;
    wr(1'b1, 8'h55);
    wr(1'b0, 8'h0F);
    chk("R10 out held", pin_out, 8'hAA);
    chk("R10 oe held", pin_oe, 8'hF0);
    @(negedge clk); sw_stby = 1'b0; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rd(1'b1, v);
    chk("R10 data kept", v, 8'hA0);
  endtask

  task automatic t_hw_stby;
    logic [7:0] v;
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h3C);
    @(negedge clk); hw_stby = 1'b1;
    #1 chk("R9 oe released at once", pin_oe, 8'h00);
    @(negedge clk); chk("R9 out cleared", pin_out, 8'h00);
    wr(1'b1, 8'h77);
    chk("R9 write ignored", pin_out, 8'h00);
    @(negedge clk); hw_stby = 1'b0;
    @(negedge clk); chk("R9 dir cleared", pin_oe, 8'h00);
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h66);
    @(negedge clk); hw_stby = 1'b1; sw_stby = 1'b1;
    @(negedge clk); chk("R11 hw wins out", pin_out, 8'h00);
    hw_stby = 1'b0;
    @(negedge clk); chk("R11 hw wins oe", pin_oe, 8'h00);
    sw_stby = 1'b0;
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rd(1'b1, v);
    chk("R11 data cleared", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_write_and_oe();
    t_read_mix();
    t_sync();
    t_modes();
    t_sw_stby();
    t_hw_stby();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule